// File: doc/BRIEF.md
# Reset Strap Capture and Power-On Configuration

This block sits behind the hardware reset pin of a 10/100 Ethernet PHY. It filters the asynchronous active-low reset pin through a synchronizer and a pulse-width counter, so that only a low level that lasts long enough (about 1 µs of reference clocks) is taken as a reset request. While an accepted reset is held, the configuration outputs show their default values and the raw strap pins are sampled on every clock. When reset is released, the last sample becomes the power-on configuration. The shared pins can then switch to their normal output functions without disturbing the configuration.

The captured configuration consists of several fields. The PHY address can later be changed through a simple write port. A software reset puts the address back to its strapped value without sampling the pins again. An isolate flag is set only by a strapped address of zero and is never changed by a register write. The remaining fields are the advertised abilities, the MII/RMII selection, the LED mode and the auto-MDIX enable. Every accepted hardware reset restores every field, not only the first one after power-up.

Top module: `phy_strap_cfg`

## Requirements
- R1: The reset pin passes through a two-flop synchronizer that clears asynchronously. A reset is accepted only when the synchronized level has been low on MIN_LOW_CYCLES (default 25) consecutive rising clock edges. A low pulse spanning K rising edges is seen on K+2 edges, so with the default it is accepted for K >= 23 and ignored, with every output unchanged, for K <= 22.
- R2: From the clock edge that accepts a reset until release, ready_o is 0 and the outputs carry the defaults: address DEF_ADDR (default 1), isolate 0, all four abilities, MII, LED mode 1, auto-MDIX on.
- R3: On release the PHY address takes the value of the five address straps, and any value from 0 to 31 is accepted.
- R4: isolate_o becomes 1 only when a release captures address 0. A later write of any address, including 0, leaves isolate_o unchanged.
- R5: Ability bits are bit0 10BASE-T half, bit1 10BASE-T full, bit2 100BASE-TX half, bit3 100BASE-TX full. Advertisement strap 0 gives 4'b0101 and strap 1 gives 4'b1111.
- R6: MAC mode strap 0 selects MII (rmii_sel_o = 0) and strap 1 selects RMII (rmii_sel_o = 1).
- R7: LED strap 1 selects LED mode 1 (led_mode2_o = 0) and strap 0 selects mode 2. MDIX strap 1 enables auto-MDIX and strap 0 disables it.
- R8: The straps must stay steady until the second rising edge after the pin rises. Strap changes after that edge have no effect on any output.
- R9: Outside a held reset, wr_en loads wr_addr into phy_addr_o on the next clock edge.
- R10: Outside a held reset, sw_rst reloads phy_addr_o with the strapped address on the next edge. It takes priority over wr_en and leaves isolate_o unchanged.
- R11: Every accepted hardware reset samples the straps again and replaces the whole configuration.
- R12: ready_o rises on the third rising edge after the pin goes high, and the configuration outputs change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| strap_addr | input | 5 | Raw PHY address strap pins |
| strap_adv | input | 1 | Raw advertisement select strap |
| strap_rmii | input | 1 | Raw MAC interface mode strap |
| strap_led | input | 1 | Raw LED mode strap (1 = mode 1) |
| strap_mdix | input | 1 | Raw auto-MDIX enable strap |
| sw_rst | input | 1 | Software reset: reload address without resampling |
| wr_en | input | 1 | Address register write strobe |
| wr_addr | input | 5 | Address write data |
| phy_addr_o | output | 5 | Current PHY address |
| isolate_o | output | 1 | MAC interface isolate flag |
| adv_o | output | 4 | Advertised ability bits |
| rmii_sel_o | output | 1 | 0 = MII, 1 = RMII |
| led_mode2_o | output | 1 | 0 = LED mode 1, 1 = LED mode 2 |
| mdix_en_o | output | 1 | Auto-MDIX enable |
| ready_o | output | 1 | 0 while an accepted hardware reset is held |

## Verification
A wrong pulse-width count appears at ready_o and at the address within a few cycles of the pin rising. A glitch that should be ignored would wipe a written address, and a valid pulse that is wrongly rejected would keep a stale one. A shadow register that is sampled one edge late, or that keeps sampling after release, shows up as wrong configuration fields on the release edge or just after the straps change. A mix-up between the strap value and the write path in the isolate logic shows at isolate_o on the first write or software reset after release.

// File: rtl/phy_strap_pkg.sv
`timescale 1ns/1ps
package phy_strap_pkg;
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned ABIL_W = 4;

   typedef struct packed {
      logic adv_all;
      logic rmii;
      logic led_pin;
      logic mdix;
   } mode_t;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      mode_t             mode;
   } strap_t;

   // ability order: 10 half, 10 full, 100 half, 100 full (bit 0 upward)
   function automatic logic [ABIL_W-1:0] abilities(input logic all_modes);
      return all_modes ? ABIL_W'(4'b1111) : ABIL_W'(4'b0101);
   endfunction
endpackage

// File: rtl/phy_rst_qual.sv
`timescale 1ns/1ps
module phy_rst_qual #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned MIN_LOW_CYCLES = 25
) (
   input  logic clk_ref,
   input  logic rst_pin_n,
   output logic sync_n,
   output logic held,
   output logic hold_phase,
   output logic release_pulse
);
   localparam int unsigned CNT_W = $clog2(MIN_LOW_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW_CYCLES - 1);

   logic [SYNC_STAGES-1:0] stage;
   logic [CNT_W-1:0]       low_cnt;
   logic                   hit;

   // clear at once, release through the chain
   always_ff @(posedge clk_ref or negedge rst_pin_n) begin
      if (!rst_pin_n) stage <= '0;
      else            stage <= {stage[SYNC_STAGES-2:0], 1'b1};
   end

   assign sync_n = stage[SYNC_STAGES-1];
   assign hit    = (low_cnt >= LAST);

   always_ff @(posedge clk_ref) begin
      if (!sync_n) begin
         if (!held) begin
            if (hit) held    <= 1'b1;
            else     low_cnt <= low_cnt + CNT_W'(1);
         end
      end else begin
         low_cnt <= '0;
         held    <= 1'b0;
      end
   end

   assign hold_phase    = !sync_n && (held || hit);
   assign release_pulse = sync_n && held;
endmodule

// File: rtl/phy_strap_latch.sv
`timescale 1ns/1ps
module phy_strap_latch
   import phy_strap_pkg::*;
#(
   parameter mode_t DEF_MODE = '{adv_all: 1'b1, rmii: 1'b0, led_pin: 1'b1, mdix: 1'b1}
) (
   input  logic   clk_ref,
   input  logic   hold_phase,
   input  logic   release_pulse,
   input  strap_t pins,
   output strap_t shadow,
   output mode_t  live
);
   always_ff @(posedge clk_ref) begin
      if (hold_phase) begin
         shadow <= pins;
         live   <= DEF_MODE;
      end else if (release_pulse) begin
         live   <= shadow.mode;
      end
   end
endmodule

// File: rtl/phy_addr_reg.sv
`timescale 1ns/1ps
module phy_addr_reg #(
   parameter int unsigned       ADDR_W   = 5,
   parameter logic [ADDR_W-1:0] DEF_ADDR = 1
) (
   input  logic              clk_ref,
   input  logic              hold_phase,
   input  logic              release_pulse,
   input  logic [ADDR_W-1:0] strap_addr,
   input  logic              sw_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] addr,
   output logic              isolate
);
   always_ff @(posedge clk_ref) begin
      if (hold_phase) begin
         addr    <= DEF_ADDR;
         isolate <= (DEF_ADDR == '0);
      end else if (release_pulse) begin
         addr    <= strap_addr;
         isolate <= (strap_addr == '0);
      end else if (sw_rst) begin
         addr    <= strap_addr;
      end else if (wr_en) begin
         addr    <= wr_data;
      end
   end
endmodule

// File: rtl/phy_strap_cfg.sv
`timescale 1ns/1ps
module phy_strap_cfg
   import phy_strap_pkg::*;
#(
   parameter int unsigned       SYNC_STAGES     = 2,
   parameter int unsigned       MIN_LOW_CYCLES  = 25,
   parameter logic [ADDR_W-1:0] DEF_ADDR        = 5'b00001,
   parameter logic              DEF_ADV_ALL     = 1'b1,
   parameter logic              DEF_RMII        = 1'b0,
   parameter logic              DEF_LED_PIN     = 1'b1,
   parameter logic              DEF_MDIX        = 1'b1,
   parameter logic              LED_MODE1_LEVEL = 1'b1
) (
   input  logic              clk_ref,
   input  logic              rst_pin_n,
   input  logic [ADDR_W-1:0] strap_addr,
   input  logic              strap_adv,
   input  logic              strap_rmii,
   input  logic              strap_led,
   input  logic              strap_mdix,
   input  logic              sw_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] phy_addr_o,
   output logic              isolate_o,
   output logic [ABIL_W-1:0] adv_o,
   output logic              rmii_sel_o,
   output logic              led_mode2_o,
   output logic              mdix_en_o,
   output logic              ready_o
);
   localparam mode_t DEF_MODE = '{adv_all: DEF_ADV_ALL, rmii: DEF_RMII,
                                  led_pin: DEF_LED_PIN, mdix: DEF_MDIX};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_LOW_CYCLES <= SYNC_STAGES) begin : g_bad_width
      $error("MIN_LOW_CYCLES must exceed SYNC_STAGES");
   end

   logic   rst_sync_n, hw_held, hold_phase, release_pulse;
   strap_t pins, shadow;
   mode_t  live;

   assign pins = '{addr: strap_addr,
                   mode: '{adv_all: strap_adv, rmii: strap_rmii,
                           led_pin: strap_led, mdix: strap_mdix}};

   phy_rst_qual #(
      .SYNC_STAGES   (SYNC_STAGES),
      .MIN_LOW_CYCLES(MIN_LOW_CYCLES)
   ) u_qual (
      .clk_ref      (clk_ref),
      .rst_pin_n    (rst_pin_n),
      .sync_n       (rst_sync_n),
      .held         (hw_held),
      .hold_phase   (hold_phase),
      .release_pulse(release_pulse)
   );

   phy_strap_latch #(.DEF_MODE(DEF_MODE)) u_latch (
      .clk_ref      (clk_ref),
      .hold_phase   (hold_phase),
      .release_pulse(release_pulse),
      .pins         (pins),
      .shadow       (shadow),
      .live         (live)
   );

   phy_addr_reg #(.ADDR_W(ADDR_W), .DEF_ADDR(DEF_ADDR)) u_addr (
      .clk_ref      (clk_ref),
      .hold_phase   (hold_phase),
      .release_pulse(release_pulse),
      .strap_addr   (shadow.addr),
      .sw_rst       (sw_rst),
      .wr_en        (wr_en),
      .wr_data      (wr_addr),
      .addr         (phy_addr_o),
      .isolate      (isolate_o)
   );

   assign adv_o      = abilities(live.adv_all);
   assign rmii_sel_o = live.rmii;
   assign mdix_en_o  = live.mdix;
   assign ready_o    = ~hw_held;

   if (LED_MODE1_LEVEL) begin : g_led_high
      assign led_mode2_o = ~live.led_pin;
   end else begin : g_led_low
      assign led_mode2_o = live.led_pin;
   end
endmodule

// File: rtl/phy_strap_cfg_check.sv
`timescale 1ns/1ps
module phy_strap_cfg_check #(
   parameter int unsigned MIN_LOW_CYCLES = 25,
   parameter logic [4:0]  DEF_ADDR       = 5'b00001,
   parameter logic        DEF_ADV_ALL    = 1'b1,
   parameter logic        DEF_RMII       = 1'b0,
   parameter logic        DEF_MDIX       = 1'b1
) (
   input logic       clk_ref,
   input logic       rst_sync_n,
   input logic       hw_held,
   input logic [4:0] shadow_addr,
   input logic       sw_rst,
   input logic       wr_en,
   input logic [4:0] wr_addr,
   input logic [4:0] phy_addr_o,
   input logic       isolate_o,
   input logic [3:0] adv_o,
   input logic       rmii_sel_o,
   input logic       led_mode2_o,
   input logic       mdix_en_o
);
   localparam int unsigned RW = $clog2(MIN_LOW_CYCLES + 2);
   localparam logic [3:0] DEF_ABIL = DEF_ADV_ALL ? 4'b1111 : 4'b0101;

   logic          armed  = 1'b0;
   logic [RW-1:0] lowrun = '0;

   always @(posedge clk_ref) begin
      if (rst_sync_n) armed <= 1'b1;
      if (rst_sync_n)                              lowrun <= '0;
      else if (lowrun != RW'(MIN_LOW_CYCLES))      lowrun <= lowrun + RW'(1);
   end

   // R1: acceptance exactly after the required number of low edges
   a_r1_min_width: assert property (@(posedge clk_ref) disable iff (!armed)
      $rose(hw_held) |-> lowrun == RW'(MIN_LOW_CYCLES));

   // R2: defaults while held
   a_r2_defaults: assert property (@(posedge clk_ref) disable iff (!armed)
      hw_held |-> (phy_addr_o == DEF_ADDR && adv_o == DEF_ABIL &&
                   rmii_sel_o == DEF_RMII && mdix_en_o == DEF_MDIX));

   // R4: isolate rises only from a release
   a_r4_iso_from_strap: assert property (@(posedge clk_ref) disable iff (!armed)
      $rose(isolate_o) |-> $past(hw_held));

   // R10 and R4: writes and soft reset leave isolate alone
   a_r10_iso_stable: assert property (@(posedge clk_ref) disable iff (!armed)
      (!hw_held && !$past(hw_held)) |-> $stable(isolate_o));

   // R9: write lands next edge
   a_r9_write: assert property (@(posedge clk_ref) disable iff (!armed)
      (!hw_held && rst_sync_n && wr_en && !sw_rst) |=> phy_addr_o == $past(wr_addr));

   // R10: soft reset restores the strapped address
   a_r10_soft_reload: assert property (@(posedge clk_ref) disable iff (!armed)
      (!hw_held && rst_sync_n && sw_rst) |=> phy_addr_o == $past(shadow_addr));

   // R8: nothing moves without a request
   a_r8_quiet: assert property (@(posedge clk_ref) disable iff (!armed)
      (!hw_held && rst_sync_n && !wr_en && !sw_rst) |=>
         ($stable(phy_addr_o) && $stable(adv_o) && $stable(rmii_sel_o) &&
          $stable(led_mode2_o) && $stable(mdix_en_o)));
endmodule

bind phy_strap_cfg phy_strap_cfg_check #(
   .MIN_LOW_CYCLES(MIN_LOW_CYCLES),
   .DEF_ADDR      (DEF_ADDR),
   .DEF_ADV_ALL   (DEF_ADV_ALL),
   .DEF_RMII      (DEF_RMII),
   .DEF_MDIX      (DEF_MDIX)
) u_check (
   .clk_ref    (clk_ref),
   .rst_sync_n (rst_sync_n),
   .hw_held    (hw_held),
   .shadow_addr(shadow.addr),
   .sw_rst     (sw_rst),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .phy_addr_o (phy_addr_o),
   .isolate_o  (isolate_o),
   .adv_o      (adv_o),
   .rmii_sel_o (rmii_sel_o),
   .led_mode2_o(led_mode2_o),
   .mdix_en_o  (mdix_en_o)
);

// File: tb/phy_strap_cfg_test.sv
`timescale 1ns/1ps
module phy_strap_cfg_test;
   localparam int MINW = 25;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] s_addr = 5'h00;
   logic       s_adv = 1'b0, s_rmii = 1'b1, s_led = 1'b0, s_mdix = 1'b0;
   logic       sw_rst = 1'b0, wr_en = 1'b0;
   logic [4:0] wr_addr = 5'h00;
   logic [4:0] phy_addr;
   logic       iso, rmii, led2, mdix, ready;
   logic [3:0] adv;

   int  checks = 0, fails = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   phy_strap_cfg uut (
      .clk_ref(clk), .rst_pin_n(rst_n), .strap_addr(s_addr), .strap_adv(s_adv),
      .strap_rmii(s_rmii), .strap_led(s_led), .strap_mdix(s_mdix),
      .sw_rst(sw_rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .phy_addr_o(phy_addr), .isolate_o(iso), .adv_o(adv), .rmii_sel_o(rmii),
      .led_mode2_o(led2), .mdix_en_o(mdix), .ready_o(ready));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit h1 = 1'b0, h2 = 1'b0, m_held = 1'b0, m_known = 1'b0;
   int m_cnt = 0;
   logic [4:0] sh_addr, e_addr;
   bit sh_adv, sh_rmii, sh_led, sh_mdix;
   bit e_iso, e_adv_all, e_rmii, e_led2, e_mdix;

   always @(posedge clk) begin
      bit view;
      view = rst_n && h1 && h2;
      if (!view && (m_held || m_cnt >= MINW - 1)) begin
         m_held = 1; m_known = 1;
         sh_addr = s_addr; sh_adv = s_adv; sh_rmii = s_rmii; sh_led = s_led; sh_mdix = s_mdix;
         e_addr = 5'h01; e_iso = 0; e_adv_all = 1; e_rmii = 0; e_led2 = 0; e_mdix = 1;
      end else if (view && m_held) begin
         m_held = 0;
         e_addr = sh_addr; e_iso = (sh_addr == 0); e_adv_all = sh_adv;
         e_rmii = sh_rmii; e_led2 = !sh_led; e_mdix = sh_mdix;
      end else if (sw_rst) e_addr = sh_addr;
      else if (wr_en)      e_addr = wr_addr;
      if (!view) begin if (!m_held) m_cnt++; end
      else m_cnt = 0;
      h2 = h1; h1 = rst_n;
   end

   always @(negedge clk) begin
      if (m_known && !done) begin
         chk("R2 ready", ready, !m_held);
         chk("R3 addr", phy_addr, e_addr);
         chk("R4 isolate", iso, e_iso);
         chk("R5 abilities", adv, e_adv_all ? 4'hF : 4'h5);
         chk("R6 mac mode", rmii, e_rmii);
         chk("R7 led", led2, e_led2);
         chk("R7 mdix", mdix, e_mdix);
      end
   end

   task automatic hw_reset(input logic [4:0] a, input bit ad, rm, ld, mx);
      @(negedge clk); #1;
      s_addr = a; s_adv = ad; s_rmii = rm; s_led = ld; s_mdix = mx; rst_n = 0;
      repeat (MINW + 10) @(negedge clk);
      chk("R2 held ready", ready, 0);
      chk("R2 held addr", phy_addr, 5'h01);
      chk("R2 held abilities", adv, 4'hF);
      #1 rst_n = 1;
      @(negedge clk);
      @(negedge clk);
      chk("R12 not yet ready", ready, 0);
      @(negedge clk);
      chk("R12 ready on third edge", ready, 1);
      #1 s_addr = ~a; s_adv = !ad; s_rmii = !rm; s_led = !ld; s_mdix = !mx;
      repeat (4) @(negedge clk);
   endtask

   task automatic write_addr(input logic [4:0] v);
      @(negedge clk); #1 wr_en = 1; wr_addr = v;
      @(negedge clk); #1 wr_en = 0;
      @(negedge clk);
   endtask

   task automatic soft_reset();
      @(negedge clk); #1 sw_rst = 1;
      @(negedge clk); #1 sw_rst = 0;
      @(negedge clk);
   endtask

   task automatic pulse(input int k);
      @(negedge clk); #1 rst_n = 0;
      repeat (k) @(negedge clk);
      #1 rst_n = 1;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // first reset, address 0 strapped, held from time zero
      repeat (MINW + 10) @(negedge clk);
      chk("R2 reset state ready", ready, 0);
      chk("R2 reset state isolate", iso, 0);
      #1 rst_n = 1;
      repeat (3) @(negedge clk);
      chk("R1 ready after release", ready, 1);
      #1 s_addr = 5'h1F; s_adv = 1; s_rmii = 0; s_led = 1; s_mdix = 1;
      repeat (4) @(negedge clk);
      chk("R3 strapped zero", phy_addr, 5'h00);
      chk("R4 isolate from strap", iso, 1);
      chk("R5 half only", adv, 4'b0101);
      chk("R6 rmii", rmii, 1);
      chk("R7 led mode 2", led2, 1);
      chk("R7 mdix off", mdix, 0);
      chk("R8 straps ignored", rmii, 1);
      write_addr(5'h05);
      chk("R9 write", phy_addr, 5'h05);
      chk("R4 write keeps isolate", iso, 1);
      soft_reset();
      chk("R10 soft reset addr", phy_addr, 5'h00);
      chk("R10 soft reset isolate", iso, 1);
      write_addr(5'h09);
      pulse(5);
      chk("R1 short pulse ignored", phy_addr, 5'h09);
      hw_reset(5'h16, 1, 0, 1, 1);
      chk("R11 new address", phy_addr, 5'h16);
      chk("R11 isolate cleared", iso, 0);
      chk("R5 all abilities", adv, 4'hF);
      chk("R6 mii", rmii, 0);
      chk("R7 led mode 1", led2, 0);
      chk("R7 mdix on", mdix, 1);
      write_addr(5'h00);
      chk("R4 write zero no isolate", iso, 0);
      chk("R9 write zero", phy_addr, 5'h00);
      soft_reset();
      chk("R10 reload strapped", phy_addr, 5'h16);
      hw_reset(5'h1F, 0, 1, 0, 1);
      chk("R3 address 31", phy_addr, 5'h1F);
      write_addr(5'h03);
      pulse(MINW - 3);
      chk("R1 boundary rejected", phy_addr, 5'h03);
      chk("R1 boundary rejected ready", ready, 1);
      pulse(MINW - 2);
      chk("R1 boundary accepted", phy_addr, 5'h00);
      chk("R1 boundary accepted isolate", iso, 1);
      repeat (4) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule